// File: doc/BRIEF.md
# Prioritized Interrupt Pending Selector

This block decides, from the state of one hart, whether a local interrupt should be taken right now and which one. It combines the raised-request vector with the per-source enable vector, then qualifies each surviving source by where it is routed. A delegation mask routes a source to the supervisor level. The current privilege and the two global enable bits, one for the machine level and one for the supervisor level, decide whether that target level may be interrupted now.

Among the sources that survive, the lowest-numbered one wins. The block reports a take flag and the index of the winner. By default both outputs follow the inputs within the same cycle and hold no state. An optional output register, chosen by a parameter, delays them by one clock. All pins are plain control signals with no handshake: the consumer samples the outputs whenever it needs a decision, and the block has no back-pressure to apply.

Top module: `irq_pick_top`

## Requirements
- R1: A source is a candidate only when both its request bit and its enable bit are 1. A request without the enable, or an enable without the request, is never taken.
- R2: A source whose delegation bit is 0 targets the machine level. It is taken at user or supervisor privilege regardless of the global enables. At machine privilege it is taken only when the machine global enable is 1.
- R3: A source whose delegation bit is 1 targets the supervisor level. It is taken at user privilege regardless of the global enables, and at supervisor privilege only when the supervisor global enable is 1. It is never taken at machine privilege.
- R4: Privilege is a 2-bit code: user = 0, supervisor = 1, machine = 3. The reserved code 2 behaves exactly like user.
- R5: When several sources qualify, cause_o is the index of the lowest-numbered one. Bit 0 has the highest priority and bit 15 the lowest.
- R6: take_o is 1 exactly when at least one source qualifies.
- R7: When no source qualifies, take_o is 0 and cause_o is 0.
- R8: With the default REG_OUT = 0, the outputs depend only on the present inputs. They change in the same cycle as the inputs, without waiting for a clock edge, and carry nothing over from earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low reset for the optional output register |
| req_i | input | 16 | Raised interrupt requests, one bit per source |
| ena_i | input | 16 | Per-source enable bits |
| to_sup_i | input | 16 | Delegation mask: 1 routes the source to the supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 reserved (as user), 3 machine |
| mach_gie_i | input | 1 | Machine-level global interrupt enable |
| sup_gie_i | input | 1 | Supervisor-level global interrupt enable |
| take_o | output | 1 | An interrupt should be taken now |
| cause_o | output | 4 | Index of the selected source, 0 when none |

## Verification
In the default build there is no state, so a wrong qualification term or a wrong priority order shows on take_o or cause_o for the same input pattern, before any clock edge. A privilege case mapped to the wrong target level shows up only for the one combination of delegation bit, privilege code and enable that crosses it. The vector table therefore visits each privilege code with the delegation bit set and clear, and with each global enable on and off. Priority errors are exposed by patterns with several qualifying bits, where the winner is not bit 0, or where masked low bits lie below the winner.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;
  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;

  // Decoded view of the current privilege for gating
  typedef struct packed {
    logic at_mach;
    logic at_super;
    logic below_super;
  } lvl_view_t;

  function automatic lvl_view_t decode_lvl(input logic [1:0] code);
    lvl_view_t v;
    v.at_mach     = (code == LVL_MACH);
    v.at_super    = (code == LVL_SUPER);
    v.below_super = (code == LVL_USER) || (code == LVL_RSVD);
    return v;
  endfunction
endpackage

// File: rtl/irq_pick_gate.sv
module irq_pick_gate
  import irq_pick_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] ena_i,
  input  logic [W-1:0] to_sup_i,
  input  logic [1:0]   priv_i,
  input  logic         mach_gie_i,
  input  logic         sup_gie_i,
  output logic [W-1:0] ok_o
);
  lvl_view_t lv;
  logic      mach_open;
  logic      sup_open;
  logic [W-1:0] cand;

  always_comb begin
    lv        = decode_lvl(priv_i);
    mach_open = !lv.at_mach || mach_gie_i;
    sup_open  = lv.below_super || (lv.at_super && sup_gie_i);
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      always_comb begin
        cand[g] = req_i[g] & ena_i[g];
        ok_o[g] = cand[g] & (to_sup_i[g] ? sup_open : mach_open);
      end
    end
  endgenerate

  // R1: nothing qualifies that is not both raised and enabled
  p_only_candidates_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o & ~(req_i & ena_i)) == '0);

  // R3: supervisor-routed sources stay closed at machine privilege
  p_sup_closed_in_mach_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3) |-> ((ok_o & to_sup_i) == '0));
endmodule

// File: rtl/irq_pick_enc.sv
module irq_pick_enc #(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  ok_i,
  output logic          any_o,
  output logic [CW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (ok_i[i]) begin
        any_o = 1'b1;
        idx_o = CW'(i);
      end
    end
  end

  // helper for the checks: bits strictly below the reported index
  logic [W-1:0] below_win;
  always_comb begin
    for (int j = 0; j < W; j++) below_win[j] = (CW'(j) < idx_o) && (j < W);
  end

  // R5: the winner is qualified and no lower bit is
  p_winner_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ok_i[idx_o]);
  p_no_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((ok_i & below_win) == '0));
  // R7: idle reports index zero
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !any_o |-> (idx_o == '0));
endmodule

// File: rtl/irq_pick_out.sv
module irq_pick_out #(
  parameter int CW      = 4,
  parameter bit REG_OUT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_i,
  input  logic [CW-1:0] idx_i,
  output logic          take_o,
  output logic [CW-1:0] cause_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          take_o  <= 1'b0;
          cause_o <= '0;
        end else begin
          take_o  <= any_i;
          cause_o <= idx_i;
        end
      end
      // R8: registered variant lags by exactly one clock
      p_reg_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (take_o == $past(any_i)) && (cause_o == $past(idx_i)));
    end else begin : g_pass
      always_comb begin
        take_o  = any_i;
        cause_o = idx_i;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top #(
  parameter int W       = 16,
  parameter int CW      = $clog2(W),
  parameter bit REG_OUT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  req_i,
  input  logic [W-1:0]  ena_i,
  input  logic [W-1:0]  to_sup_i,
  input  logic [1:0]    priv_i,
  input  logic          mach_gie_i,
  input  logic          sup_gie_i,
  output logic          take_o,
  output logic [CW-1:0] cause_o
);
  logic [W-1:0]  ok;
  logic          any;
  logic [CW-1:0] idx;

  irq_pick_gate #(.W(W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .req_i(req_i), .ena_i(ena_i), .to_sup_i(to_sup_i),
    .priv_i(priv_i), .mach_gie_i(mach_gie_i), .sup_gie_i(sup_gie_i),
    .ok_o(ok)
  );

  irq_pick_enc #(.W(W), .CW(CW)) u_enc (
    .clk(clk), .rst_n(rst_n), .ok_i(ok), .any_o(any), .idx_o(idx)
  );

  irq_pick_out #(.CW(CW), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .any_i(any), .idx_i(idx),
    .take_o(take_o), .cause_o(cause_o)
  );

  // R2: machine-routed sources are closed at machine privilege with the gate off
  p_mach_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3 && !mach_gie_i) |-> !any);
  // R6: a take decision needs a raised and enabled source
  p_take_needs_cand_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((req_i & ena_i) != '0));
  // R3: at user level any raised and enabled source is taken
  p_user_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd0 && (req_i & ena_i) != '0) |-> any);
endmodule

// File: tb/sim_irq_pick_top.sv
module sim_irq_pick_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req, ena, dlg;
  logic [1:0]  priv;
  logic        mg, sg;
  logic        take;
  logic [3:0]  cause;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_pick_top u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ena_i(ena), .to_sup_i(dlg),
    .priv_i(priv), .mach_gie_i(mg), .sup_gie_i(sg),
    .take_o(take), .cause_o(cause)
  );

  // {req, ena, deleg, priv, mach_gie, sup_gie, exp_take, exp_cause}
  localparam int NV = 16;
  localparam logic [56:0] VEC [NV] = '{
    {16'h0001, 16'h0001, 16'h0000, 2'd3, 1'b1, 1'b0, 1'b1, 4'd0},  // R2 M open
    {16'h0001, 16'h0001, 16'h0000, 2'd3, 1'b0, 1'b0, 1'b0, 4'd0},  // R2 M closed
    {16'h0080, 16'h0080, 16'h0000, 2'd1, 1'b0, 1'b0, 1'b1, 4'd7},  // R2 at S
    {16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b1, 1'b0, 1'b0, 4'd0},  // R3 S closed
    {16'h0020, 16'h0020, 16'h0020, 2'd1, 1'b0, 1'b1, 1'b1, 4'd5},  // R3 S open
    {16'h0020, 16'h0020, 16'h0020, 2'd3, 1'b1, 1'b1, 1'b0, 4'd0},  // R3 never at M
    {16'h0020, 16'h0020, 16'h0020, 2'd0, 1'b0, 1'b0, 1'b1, 4'd5},  // R3 at U
    {16'h0020, 16'h0020, 16'h0020, 2'd2, 1'b0, 1'b0, 1'b1, 4'd5},  // R4 rsvd as U
    {16'h0002, 16'h0002, 16'h0000, 2'd2, 1'b0, 1'b0, 1'b1, 4'd1},  // R4 rsvd as U
    {16'hFFFF, 16'h0000, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'd0},  // R1 no enable
    {16'h0F00, 16'hFF00, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd8},  // R5
    {16'h8000, 16'h8000, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b1, 4'd15}, // R5 top bit
    {16'hA0A0, 16'hFFFF, 16'h00FF, 2'd3, 1'b1, 1'b1, 1'b1, 4'd13}, // R5 mix at M
    {16'hA0A0, 16'hFFFF, 16'h00FF, 2'd1, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 mix at S
    {16'hA0A0, 16'hFFFF, 16'h00FF, 2'd1, 1'b0, 1'b0, 1'b1, 4'd13}, // R5 mix S closed
    {16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 4'd0}   // R7 none raised
  };

  task automatic check(input string tag, input logic et, input logic [3:0] ec);
    n_chk++;
    if (take !== et || (et && cause !== ec) || (!et && cause !== 4'd0)) begin
      n_bad++;
      $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
               tag, take, cause, et, et ? ec : 4'd0);
    end
  endtask

  task automatic drive(input logic [15:0] r, input logic [15:0] e,
                       input logic [15:0] d, input logic [1:0] p,
                       input logic m, input logic s);
    req = r; ena = e; dlg = d; priv = p; mg = m; sg = s;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    drive(16'h0, 16'h0, 16'h0, 2'd0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 reset idle", 1'b0, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k][56:41], VEC[k][40:25], VEC[k][24:9], VEC[k][8:7],
            VEC[k][6], VEC[k][5]);
      #1;
      check($sformatf("R2-R7 table row %0d", k), VEC[k][4], VEC[k][3:0]);
    end

    // R6: all raised and enabled at user level, bit 0 wins
    @(negedge clk);
    drive(16'hFFFF, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0);
    #1 check("R6 all qualify", 1'b1, 4'd0);

    // R8: outputs follow inputs between clock edges, no memory
    @(posedge clk);
    #0.5;
    drive(16'h0400, 16'h0400, 16'h0000, 2'd1, 1'b0, 1'b0);
    #0.5 check("R8 same-cycle update", 1'b1, 4'd10);
    drive(16'h0000, 16'h0400, 16'h0000, 2'd1, 1'b0, 1'b0);
    #0.5 check("R8 no carry-over", 1'b0, 4'd0);

    // R1: enabled but not raised
    @(negedge clk);
    drive(16'h0000, 16'hFFFF, 16'hFFFF, 2'd0, 1'b1, 1'b1);
    #1 check("R1 enable without request", 1'b0, 4'd0);

    // R4: reserved code does not open machine-routed bit like machine would close it
    @(negedge clk);
    drive(16'h0008, 16'h0008, 16'h0000, 2'd2, 1'b0, 1'b0);
    #1 check("R4 rsvd not machine", 1'b1, 4'd3);

    // R2: masked low bit must not hide a qualifying higher bit
    @(negedge clk);
    drive(16'h0011, 16'h0011, 16'h0001, 2'd3, 1'b1, 1'b1);
    #1 check("R2 R5 skip closed low bit", 1'b1, 4'd4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule